// File: doc/BRIEF.md
# Page Access Permission Checker

This block is the permission stage that follows page translation. For each access it receives the attribute bits of the page: present, user-accessible, writable and no-execute. It also receives the current privilege level, the supervisor write-protect control and the no-execute enable control, and it is told whether the access is a read, a write or an instruction fetch. It decides whether the access may proceed or must raise a page fault. When the access faults, it also builds the matching error code.

Requests enter through a valid/ready handshake and pass through one register stage. The verdict leaves through a second valid/ready handshake one cycle after the request is accepted. A stalled verdict is held unchanged until it is taken. Table walking, translation caching and accessed/dirty updates are done elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: A privilege level numerically at or above `USER_LEVEL` (default 3) counts as user mode. Lower levels count as supervisor mode.
- R2: An access to a page whose present input is 0 always faults. Its error code has bit 0 cleared.
- R3: A user-mode access of any kind to a page whose user-accessible input is 0 faults.
- R4: A user-mode write (kind code 1) to a page whose writable input is 0 faults.
- R5: A supervisor-mode write to a page whose writable input is 0 is allowed while the write-protect control is 0. It faults while the write-protect control is 1.
- R6: An instruction fetch (kind code 2) from a page whose no-execute input is 1 faults only while the no-execute enable control is 1. While that control is 0, the no-execute bit has no effect.
- R7: A read (kind code 0) is allowed on any present page that the current mode may access. Kind code 3 is treated exactly as a read.
- R8: On a fault the 5-bit error code carries the following bits:
  - bit 0: the present input.
  - bit 1: set for a write.
  - bit 2: set in user mode.
  - bit 3: 0.
  - bit 4: set for a fetch.
  When the access is allowed, the error code is all zero.
- R9: A request is accepted on a clock edge where in_valid and in_ready are both 1. Its verdict appears with out_valid on the next cycle. in_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_fault and out_err stay unchanged.
- R11: Synchronous active-high reset clears out_valid, which drops a pending verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Stage can take a request |
| in_cpl | input | PRIV_W | Current privilege level |
| in_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| pg_present | input | 1 | Page present attribute |
| pg_user | input | 1 | Page accessible from user mode |
| pg_writable | input | 1 | Page writable attribute |
| pg_nx | input | 1 | Page no-execute attribute |
| ctl_wp | input | 1 | Supervisor write-protect control |
| ctl_nxe | input | 1 | No-execute enable control |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Consumer takes the verdict |
| out_fault | output | 1 | 1 = page fault, 0 = allowed |
| out_err | output | 5 | Fault error code |

## Verification
The bench builds the block with its default parameters: a 2-bit privilege level with user mode starting at level 3. With these values, every combination of level, access kind, the four page attributes and the two controls can be swept, 1024 requests in all, so each rule and every rule overlap is visited. The consumer's ready is randomised, which makes the combinational ready path and the holding of stalled verdicts active throughout the sweep. A long forced stall and a reset with a verdict pending cover the hold and reset-drop cases.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    localparam int ERR_W      = 5;
    localparam int ERR_PRES   = 0;
    localparam int ERR_WRITE  = 1;
    localparam int ERR_USER   = 2;
    localparam int ERR_FETCH  = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic present;
        logic user_ok;
        logic writable;
        logic no_exec;
    } pg_attr_t;

    typedef struct packed {
        logic wp;
        logic nxe;
    } pg_ctl_t;

    typedef struct packed {
        logic             fault;
        logic [ERR_W-1:0] err;
    } verdict_t;

    function automatic logic [ERR_W-1:0] make_err(
        input logic present,
        input logic is_write,
        input logic is_user,
        input logic is_fetch
    );
        logic [ERR_W-1:0] e;
        e            = '0;
        e[ERR_PRES]  = present;
        e[ERR_WRITE] = is_write;
        e[ERR_USER]  = is_user;
        e[ERR_FETCH] = is_fetch;
        return e;
    endfunction

endpackage

// File: rtl/pchk_mode.sv
module pchk_mode #(
    parameter int PRIV_W     = 2,
    parameter int USER_LEVEL = 3
) (
    input  logic [PRIV_W-1:0] cpl,
    output logic              is_user
);
    localparam logic [PRIV_W-1:0] USER_LV = PRIV_W'(USER_LEVEL);

    always_comb is_user = (cpl >= USER_LV);
endmodule

// File: rtl/pchk_eval.sv
module pchk_eval
    import pchk_pkg::*;
(
    input  acc_kind_e kind,
    input  pg_attr_t  attr,
    input  pg_ctl_t   ctl,
    input  logic      is_user,
    output verdict_t  verdict
);
    logic wr, fx;
    logic deny_mode, deny_write, deny_exec, fault;

    always_comb begin
        wr         = (kind == ACC_WRITE);
        fx         = (kind == ACC_FETCH);
        deny_mode  = is_user && !attr.user_ok;
        deny_write = wr && !attr.writable && (is_user || ctl.wp);
        deny_exec  = fx && attr.no_exec && ctl.nxe;
        fault      = !attr.present || deny_mode || deny_write || deny_exec;
        verdict.fault = fault;
        verdict.err   = fault ? make_err(attr.present, wr, is_user, fx) : '0;
    end
endmodule

// File: rtl/pchk_stage.sv
module pchk_stage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    always_comb in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import pchk_pkg::*;
#(
    parameter int PRIV_W     = 2,
    parameter int USER_LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PRIV_W-1:0] in_cpl,
    input  logic [1:0]        in_kind,
    input  logic              pg_present,
    input  logic              pg_user,
    input  logic              pg_writable,
    input  logic              pg_nx,
    input  logic              ctl_wp,
    input  logic              ctl_nxe,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_fault,
    output logic [ERR_W-1:0]  out_err
);
    localparam int VW = $bits(verdict_t);

    logic     is_user;
    pg_attr_t attr;
    pg_ctl_t  ctl;
    verdict_t now_v, held_v;

    always_comb begin
        attr.present  = pg_present;
        attr.user_ok  = pg_user;
        attr.writable = pg_writable;
        attr.no_exec  = pg_nx;
        ctl.wp        = ctl_wp;
        ctl.nxe       = ctl_nxe;
    end

    pchk_mode #(.PRIV_W(PRIV_W), .USER_LEVEL(USER_LEVEL)) u_mode (
        .cpl     (in_cpl),
        .is_user (is_user)
    );

    pchk_eval u_eval (
        .kind    (acc_kind_e'(in_kind)),
        .attr    (attr),
        .ctl     (ctl),
        .is_user (is_user),
        .verdict (now_v)
    );

    pchk_stage #(.W(VW)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (now_v),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (held_v)
    );

    always_comb begin
        out_fault = held_v.fault;
        out_err   = held_v.err;
    end
endmodule

// File: rtl/pchk_checker.sv
module pchk_checker #(
    parameter int PRIV_W     = 2,
    parameter int USER_LEVEL = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PRIV_W-1:0] in_cpl,
    input logic [1:0]        in_kind,
    input logic              pg_present,
    input logic              pg_user,
    input logic              pg_writable,
    input logic              pg_nx,
    input logic              ctl_wp,
    input logic              ctl_nxe,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_fault,
    input logic [4:0]        out_err
);
    localparam logic [PRIV_W-1:0] ULV = PRIV_W'(USER_LEVEL);

    logic take;
    always_comb take = in_valid && in_ready;

    // R11
    a_r11_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    a_r2_absent_faults: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take && !pg_present)) |-> (out_valid && out_fault && !out_err[0]));

    // R3
    a_r3_user_blocked: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take && pg_present && (in_cpl >= ULV) && !pg_user))
        |-> (out_valid && out_fault && out_err[2]));

    // R6
    a_r6_noexec_fetch: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take && in_kind == 2'd2 && pg_nx && ctl_nxe))
        |-> (out_valid && out_fault && out_err[4]));

    // R8
    a_r8_clean_when_allowed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fault) |-> (out_err == 5'd0));

    // R8
    a_r8_bit3_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_err[3]);

    // R9
    a_r9_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    a_r9_accept_shows: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_fault) && $stable(out_err)));
endmodule

bind page_perm_check pchk_checker #(.PRIV_W(PRIV_W), .USER_LEVEL(USER_LEVEL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_cpl      (in_cpl),
    .in_kind     (in_kind),
    .pg_present  (pg_present),
    .pg_user     (pg_user),
    .pg_writable (pg_writable),
    .pg_nx       (pg_nx),
    .ctl_wp      (ctl_wp),
    .ctl_nxe     (ctl_nxe),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_fault   (out_fault),
    .out_err     (out_err)
);

// File: tb/page_perm_check_bench.sv
module page_perm_check_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_cpl = '0;
    logic [1:0] in_kind = '0;
    logic       pg_present = 1'b0, pg_user = 1'b0, pg_writable = 1'b0, pg_nx = 1'b0;
    logic       ctl_wp = 1'b0, ctl_nxe = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_fault;
    logic [4:0] out_err;

    int checks = 0;
    int errors = 0;
    bit stall  = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit     fault;
        int     err;
        string  tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    page_perm_check u_page_perm_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cpl(in_cpl), .in_kind(in_kind), .pg_present(pg_present),
        .pg_user(pg_user), .pg_writable(pg_writable), .pg_nx(pg_nx),
        .ctl_wp(ctl_wp), .ctl_nxe(ctl_nxe), .out_valid(out_valid),
        .out_ready(out_ready), .out_fault(out_fault), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference built from the requirement text
    function automatic exp_t model(int cpl, int kind, bit p, bit u, bit w, bit nx, bit wp, bit nxe);
        exp_t e;
        bit usr = (cpl >= 3);               // R1
        bit isw = (kind == 1);
        bit isf = (kind == 2);
        bit f   = 0;
        e.tag = "R7";
        if (isf && nx) e.tag = "R6";
        if (isw && !w) e.tag = usr ? "R4" : "R5";
        if (usr && !u) e.tag = "R3";
        if (!p) e.tag = "R2";
        if (!p) f = 1;
        if (usr && !u) f = 1;
        if (isw && !w && usr) f = 1;
        if (isw && !w && !usr && wp) f = 1;
        if (isf && nx && nxe) f = 1;
        e.fault = f;
        e.err   = f ? (int'(p) + 2*int'(isw) + 4*int'(usr) + 16*int'(isf)) : 0;
        e.tag   = {e.tag, "/R8/R1"};
        return e;
    endfunction

    // Cycle-by-cycle compare, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            q.delete();
        end else if (!finished) begin
            check(out_valid == (q.size() != 0), "R9 out_valid", out_valid, q.size() != 0);
            check(in_ready == (q.size() == 0 || out_ready), "R9 in_ready", in_ready,
                  q.size() == 0 || out_ready);
            if (q.size() != 0 && out_valid) begin
                check(out_fault == q[0].fault, {q[0].tag, stall ? "/R10" : "", " fault"},
                      out_fault, q[0].fault);
                check(int'(out_err) == q[0].err, {q[0].tag, stall ? "/R10" : "", " err"},
                      out_err, q[0].err);
            end
            if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
            if (in_valid && in_ready)
                q.push_back(model(in_cpl, in_kind, pg_present, pg_user, pg_writable,
                                  pg_nx, ctl_wp, ctl_nxe));
        end
    end

    // Consumer ready
    always @(posedge clk) begin
        #1;
        out_ready <= stall ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    task automatic send(input int combo);
        @(posedge clk); #1;
        in_valid    = 1'b1;
        pg_present  = combo[0];
        pg_user     = combo[1];
        pg_writable = combo[2];
        pg_nx       = combo[3];
        ctl_wp      = combo[4];
        ctl_nxe     = combo[5];
        in_kind     = combo[7:6];
        in_cpl      = combo[9:8];
        do @(negedge clk); while (!(in_valid && in_ready));
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        @(posedge clk); #1;
        rst = 1'b0;

        // full sweep of level, kind, attributes and controls
        for (int c = 0; c < 1024; c++) send(c);

        // R10: long stall with a faulting verdict pending
        stall = 1'b1;
        send(10'b11_01_010001); // user write to read-only present page
        repeat (6) @(posedge clk);
        stall = 1'b0;
        repeat (4) @(posedge clk);

        // R11: reset while a verdict is pending
        stall = 1'b1;
        send(10'b00_10_001001);
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 pending dropped", out_valid, 0);
        stall = 1'b0;
        repeat (4) @(posedge clk);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule